// File: doc/BRIEF.md
# Daisy-Chained Serial Shift Node

This block is one node of a serial ring. Identical nodes are wired in series: the serial output of each node feeds the serial input of the next. A single serial clock and a single frame strobe run to every node in parallel. While the frame strobe is low, each node behaves as a plain 8-bit shift register. Bits ripple through the chain, and each node needs exactly eight clock periods to pass a byte on. A chain of eight nodes therefore holds a complete frame after 64 clocks.

When the frame strobe goes high, every node acts in the same event. Each one captures the byte now sitting in its register as received data, with a one-cycle valid pulse. It also loads its local transmit byte into the register for the next frame. There is no per-node select. The position of a node in the chain decides which byte it receives.

The serial clock, the frame strobe and the serial input are asynchronous to the system clock. Each one passes through a two-flop synchroniser before edge detection. Every serial level must therefore stay stable for at least three system clocks.

Top module: `chain_node`

## Requirements
- R1: After reset, `rx_byte_o` is 0x00, `rx_valid_o` is 0 and `ser_dout_o` is 0. The internal shift register is zero, so until the first frame strobe the node shifts out zeros.
- R2: On each rising edge of `ser_clk_i` while `ser_frm_i` is low, the node samples `ser_din_i` into bit 0 of its register and moves the other bits one place toward bit 7. A bit entering the node reaches `ser_dout_o` after eight rising edges.
- R3: `ser_dout_o` changes only after a falling edge of `ser_clk_i` or a rising edge of `ser_frm_i`. It then shows bit 7 of the register, so downstream nodes sample a stable value on the next rising edge.
- R4: On a rising edge of `ser_frm_i` (active high), `rx_byte_o` takes the register contents: the last eight bits shifted in, the earliest at bit 7. `rx_valid_o` is high for exactly one system clock.
- R5: On the same frame edge, the register loads `tx_byte_i`. Its bit 7 appears on `ser_dout_o` at once, and the remaining bits follow MSB first, one per falling clock edge.
- R6: While `ser_frm_i` is high, edges on `ser_clk_i` do not shift the register and do not change `ser_dout_o`.
- R7: Between frame edges, changes on `tx_byte_i` have no effect on the serial output, and `rx_byte_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Shared serial clock (asynchronous) |
| ser_frm_i | input | 1 | Shared frame strobe, active high (asynchronous) |
| ser_din_i | input | 1 | Serial data from the previous node |
| ser_dout_o | output | 1 | Serial data to the next node |
| tx_byte_i | input | 8 | Local byte loaded at the next frame edge |
| rx_byte_o | output | 8 | Byte captured at the last frame edge |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_byte_o` updates |

## Verification
The hardest case to reach is serial clock activity while the frame strobe is held high. A correct node must then freeze both its register and its output. Many frames also leave the register only partly refilled. To reach both cases, the stimulus randomly toggles the serial clock with random data during some frame strobes. It also varies the number of bits between frames from zero to twelve, so that captured bytes mix freshly shifted bits with leftovers of the loaded transmit byte. The transmit input is changed at random between frames to show that only the frame edge samples it.

// File: rtl/chain_node_pkg.sv
// Package: shared widths and types for the daisy-chain shift node.
// Assumes the byte width is at least 2 bits.
package chain_node_pkg;
    parameter int unsigned NODE_W      = 8;
    parameter int unsigned SYNC_STAGES = 2;

    typedef logic [NODE_W-1:0] node_word_t;

    // Order of the lines inside the shared synchroniser vector.
    localparam int unsigned LN_CLK = 0;
    localparam int unsigned LN_FRM = 1;
    localparam int unsigned LN_DIN = 2;
    localparam int unsigned N_LINES = 3;
endpackage

// File: rtl/line_sync.sv
// Module: line_sync
// Brings a vector of asynchronous lines into the system clock domain
// through STAGES flops per line. Reports the settled level and one-cycle
// rise and fall pulses for each line. Assumes every input level lasts
// at least STAGES+1 system clocks.
module line_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain_q;

            // Shift the raw line through the synchroniser flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
            end

            assign level_o[g] = chain_q[STAGES-1];
        end
    endgenerate

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_o;
    end

    assign rise_o = level_o & ~prev_q;
    assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/shift_core.sv
// Module: shift_core
// The node's shift register and serial output flop. Shifts in on
// shift_en, drives the MSB out on drive_en, and reloads from load_val on
// load_en, which wins over everything else. Assumes the enables are
// one-cycle pulses from the synchroniser.
module shift_core
    import chain_node_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       drive_en,
    input  logic       load_en,
    input  logic       frame_hi,
    input  logic       din_s,
    input  node_word_t load_val,
    output node_word_t sr_o,
    output logic       dout_o
);
    node_word_t sr_q;
    logic       dout_q;

    // Shift register: reload on frame, otherwise shift on a rising clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (load_en)  sr_q <= load_val;
        else if (shift_en) sr_q <= {sr_q[NODE_W-2:0], din_s};
    end

    // Output flop: present the MSB after a falling clock or a reload.
    always_ff @(posedge clk) begin
        if (!rst_n)        dout_q <= 1'b0;
        else if (load_en)  dout_q <= load_val[NODE_W-1];
        else if (drive_en) dout_q <= sr_q[NODE_W-1];
    end

    assign sr_o   = sr_q;
    assign dout_o = dout_q;

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (sr_q[0] == $past(din_s)));

    assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en && !load_en) |=> $stable(dout_q));

    assert_frozen_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_hi && !load_en) |=> $stable(sr_q));
endmodule

// File: rtl/rx_hold.sv
// Module: rx_hold
// Receive holding register and its one-cycle valid pulse. Captures the
// shift register when capture_en fires. Assumes capture_en never fires on
// two consecutive cycles.
module rx_hold
    import chain_node_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_en,
    input  node_word_t sr_i,
    output node_word_t rx_o,
    output logic       valid_o
);
    node_word_t rx_q;
    logic       valid_q;

    // Hold the captured byte and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture_en;
            if (capture_en) rx_q <= sr_i;
        end
    end

    assign rx_o    = rx_q;
    assign valid_o = valid_q;

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    assert_rx_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(rx_q));
endmodule

// File: rtl/chain_node.sv
// Module: chain_node
// One node of a serial daisy chain. Acts as a shift register while the
// frame strobe is low. On the strobe's rising edge it captures the
// received byte and loads the local transmit byte. Assumes the serial
// clock, frame and data are asynchronous and each level lasts at least
// three system clocks.
module chain_node
    import chain_node_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk_i,
    input  logic       ser_frm_i,
    input  logic       ser_din_i,
    output logic       ser_dout_o,
    input  logic [7:0] tx_byte_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o
);
    logic [N_LINES-1:0] raw, lvl, rise, fall;
    node_word_t         sr;
    logic               shift_en;

    // Gather the asynchronous lines in the package's order.
    always_comb begin
        raw         = '0;
        raw[LN_CLK] = ser_clk_i;
        raw[LN_FRM] = ser_frm_i;
        raw[LN_DIN] = ser_din_i;
    end

    line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign shift_en = rise[LN_CLK] & ~lvl[LN_FRM];

    shift_core u_core (
        .clk(clk), .rst_n(rst_n),
        .shift_en(shift_en), .drive_en(fall[LN_CLK]),
        .load_en(rise[LN_FRM]), .frame_hi(lvl[LN_FRM]),
        .din_s(lvl[LN_DIN]), .load_val(tx_byte_i),
        .sr_o(sr), .dout_o(ser_dout_o)
    );

    rx_hold u_rx (
        .clk(clk), .rst_n(rst_n), .capture_en(rise[LN_FRM]),
        .sr_i(sr), .rx_o(rx_byte_o), .valid_o(rx_valid_o)
    );
endmodule

// File: tb/chain_node_tb.sv
// Bench for chain_node: directed corner cases plus seeded random frames,
// checked against a shift-register model kept by bench tasks.
module chain_node_tb;
    localparam int H = 6;  // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_frm = 1'b0, ser_din = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       ser_dout, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] m_sr = 8'h00;
    logic [7:0] m_rx = 8'h00;

    always #5 clk = ~clk;

    chain_node u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_frm_i(ser_frm), .ser_din_i(ser_din),
        .ser_dout_o(ser_dout), .tx_byte_i(tx_byte),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
    );

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One serial bit while the frame is low.
    task automatic xfer_bit(bit d);
        ser_din = d;
        chk(ser_dout == m_sr[7], "R2", "serial out before rise", ser_dout, m_sr[7]);
        ser_clk = 1'b1;
        hold(H);
        m_sr = {m_sr[6:0], d};
        chk(rx_byte == m_rx, "R7", "rx held between frames", rx_byte, m_rx);
        ser_clk = 1'b0;
        hold(H);
    endtask

    // Frame strobe, optionally with serial clock noise while it is high.
    task automatic frame(logic [7:0] tx, bit noise);
        int vcnt = 0;
        tx_byte = tx;
        ser_frm = 1'b1;
        for (int i = 0; i < H; i++) begin
            hold(1);
            if (rx_valid) vcnt++;
        end
        chk(vcnt == 1, "R4", "valid pulse count", vcnt, 1);
        chk(rx_byte == m_sr, "R4", "captured byte", rx_byte, m_sr);
        m_rx = m_sr;
        m_sr = tx;
        chk(ser_dout == tx[7], "R5", "MSB shown at load", ser_dout, tx[7]);
        if (noise) begin
            for (int k = 0; k < 3; k++) begin
                ser_din = 1'($urandom);
                ser_clk = 1'b1;
                hold(H);
                ser_clk = 1'b0;
                hold(H);
                chk(ser_dout == tx[7], "R6", "output frozen in frame", ser_dout, tx[7]);
            end
        end
        ser_frm = 1'b0;
        hold(H);
        tx_byte = 8'($urandom);  // R7: must not affect the serial stream
    endtask

    initial begin
        void'($urandom(32'd1234));
        hold(3);
        rst_n = 1'b1;
        hold(2);
        chk(rx_byte == 8'h00, "R1", "rx after reset", rx_byte, 0);
        chk(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);
        chk(ser_dout == 1'b0, "R1", "dout after reset", ser_dout, 0);
        // R1: zeros shift out before any frame.
        for (int i = 0; i < 4; i++) xfer_bit(1'b1);

        // Directed: load A5, shift in 3C, verify both directions.
        frame(8'hA5, 1'b0);
        for (int i = 7; i >= 0; i--) xfer_bit(bit'((8'h3C >> i) & 1));
        frame(8'h00, 1'b0);
        chk(m_rx == 8'h3C, "R4", "directed byte", rx_byte, 8'h3C);

        // Directed: noise in frame, then a full byte must show the load.
        frame(8'hC3, 1'b1);
        for (int i = 0; i < 8; i++) xfer_bit(1'b0);
        // Partial shift: three bits only.
        frame(8'h81, 1'b0);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1);
        frame(8'h7E, 1'b0);

        // Random frames.
        for (int f = 0; f < 40; f++) begin
            int nb = int'($urandom % 13);
            for (int b = 0; b < nb; b++) xfer_bit(1'($urandom));
            frame(8'($urandom), 1'($urandom % 3 == 0));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule